// File: doc/BRIEF.md
# Watchdog Reset Timer

This block supervises a processor by timing a fixed interval from the main system clock. Software proves it is alive by sending a restart pulse before the interval runs out. If no restart arrives in time and resets are enabled, the block raises a reset request for a fixed number of clocks. It also sets a sticky cause flag so that code running after the reset can tell that the watchdog caused it.

The interval is counted in machine cycles of `PRESCALE` clocks each. `MACHINE_CYCLES` of them make one interval. With the defaults of 12 and 122,800, one interval is 1,473,600 clocks. That is about 92 ms at 16 MHz and about 800 ms at 1.8432 MHz.

The restart pulse and the reset-enable level come from a separate write-protection unit. This block takes them as clean bit-level controls. After power-on reset the counter stays at zero until the first restart arrives.

Top module: `wdt_reset_timer`

## Requirements
- R1: After power-on reset, `reset_req` and `cause_flag` are 0, and no reset request is ever raised before the first `restart_pulse`, even with `reset_enable` at 1.
- R2: When `reset_enable` is 1, `reset_req` rises exactly `PRESCALE*MACHINE_CYCLES` clocks after the clock edge that sampled `restart_pulse` high.
- R3: A restart before expiry reloads the count. The next timeout comes `PRESCALE*MACHINE_CYCLES` clocks after the latest restart, not after the earlier one.
- R4: If `reset_enable` is 0 at expiry, no reset request is raised and `cause_flag` does not change. The counter wraps to zero and times a new full interval from that edge.
- R5: `reset_req` stays high for exactly `PULSE_LEN` consecutive clocks.
- R6: `cause_flag` is set on the same edge where `reset_req` rises. It stays set through the pulse and after it ends.
- R7: `cause_flag` is cleared only by `rst_n` low or by `cause_clear`. If `cause_clear` arrives on the same edge as a watchdog reset, the flag is set.
- R8: A synchronous `rst_n` low clears `reset_req` and `cause_flag` on the next edge and disarms the counter until the next restart.
- R9: While `reset_req` is high the counter is held at zero and restarts are ignored. The counter starts timing when the pulse ends, so the next request follows `PRESCALE*MACHINE_CYCLES` clocks after the edge where `reset_req` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main system clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| restart_pulse | input | 1 | One-cycle restart from the protected access path |
| reset_enable | input | 1 | Enable-reset level from the protected access path |
| cause_clear | input | 1 | Software clear of the cause flag |
| reset_req | output | 1 | Reset request to the processor, held PULSE_LEN clocks |
| cause_flag | output | 1 | Sticky flag: the last reset came from the watchdog |

## Verification
All results are counted in clock edges from the edge that sampled the stimulus. A restart edge E puts the rising `reset_req` at edge E+P*M. The pulse falls at E+P*M+L. The next unattended request comes at E+2*P*M+L. Flag clears and `rst_n` take effect on the edge that samples them.

The driver tasks record the edge number when they apply a stimulus. From that number they enqueue expected values for particular cycles. Some entries fall one cycle before an event and some on the event itself, so an early or late edge shows up as a mismatch. The monitor samples at the falling clock edge, once the registered outputs for that cycle have settled.

// File: rtl/wdt_pkg.sv
// Shared types and helpers for the watchdog reset timer.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package wdt_pkg;

    // State of the reset-request stretcher.
    typedef enum logic {
        PS_IDLE = 1'b0,
        PS_HOLD = 1'b1
    } pulse_state_e;

    // Bit width able to hold values 0..n-1, never narrower than 1.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
// Divides the system clock into machine-cycle ticks.
// Emits one tick every PRESCALE clocks while run is high; clr returns to phase zero.
// Assumes: clr and run come from registered control in the parent.
module wdt_prescaler #(
    parameter int unsigned PRESCALE = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    import wdt_pkg::*;

    localparam int unsigned PRE_W = cnt_width(PRESCALE);

    generate
        if (PRESCALE > 1) begin : g_div
            logic [PRE_W-1:0] phase;

            // Advance the sub-cycle phase, wrapping at the end of each machine cycle.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    phase <= '0;
                else if (clr)
                    phase <= '0;
                else if (run)
                    phase <= (phase == PRE_W'(PRESCALE - 1)) ? '0 : phase + 1'b1;
            end

            assign tick = run && (phase == PRE_W'(PRESCALE - 1));

            AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                phase <= PRE_W'(PRESCALE - 1)); // R2

            AST_PHASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
                !run && !clr |=> $stable(phase)); // R9
        end else begin : g_bypass
            logic unused_ok;
            assign unused_ok = clk ^ rst_n ^ clr;
            assign tick      = run;
        end
    endgenerate

endmodule

// File: rtl/wdt_interval_counter.sv
// Counts machine-cycle ticks and flags the last tick of the interval.
// expire is high for one clock when the MACHINE_CYCLES-th tick occurs.
// Assumes: the parent clears this counter on expire, restart or when disarmed.
module wdt_interval_counter #(
    parameter int unsigned MACHINE_CYCLES = 122800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expire
);
    import wdt_pkg::*;

    localparam int unsigned CNT_W = cnt_width(MACHINE_CYCLES);

    logic [CNT_W-1:0] mcount;

    // Count elapsed machine cycles since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mcount <= '0;
        else if (clr)
            mcount <= '0;
        else if (tick)
            mcount <= mcount + 1'b1;
    end

    assign expire = tick && (mcount == CNT_W'(MACHINE_CYCLES - 1));

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mcount <= CNT_W'(MACHINE_CYCLES - 1)); // R2

    AST_COUNT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !clr |=> $stable(mcount)); // R3

endmodule

// File: rtl/wdt_reset_pulser.sv
// Stretches an enabled expiry into a PULSE_LEN-clock reset request and
// keeps the sticky reset-cause flag.
// Assumes: expire cannot occur while a pulse is in progress (parent stops counting).
module wdt_reset_pulser #(
    parameter int unsigned PULSE_LEN = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic reset_enable,
    input  logic cause_clear,
    output logic reset_req,
    output logic cause_flag
);
    import wdt_pkg::*;

    localparam int unsigned LEN_W = cnt_width(PULSE_LEN);

    pulse_state_e     state;
    logic [LEN_W-1:0] held;
    logic             fire;

    assign fire = expire && reset_enable;

    // Sequence idle -> hold for PULSE_LEN clocks -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_IDLE;
            held  <= '0;
        end else begin
            case (state)
                PS_IDLE: begin
                    held <= '0;
                    if (fire)
                        state <= PS_HOLD;
                end
                PS_HOLD: begin
                    if (held == LEN_W'(PULSE_LEN - 1)) begin
                        state <= PS_IDLE;
                        held  <= '0;
                    end else begin
                        held <= held + 1'b1;
                    end
                end
                default: state <= PS_IDLE;
            endcase
        end
    end

    // Keep the cause flag; a new watchdog reset wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause_flag <= 1'b0;
        else if (fire)
            cause_flag <= 1'b1;
        else if (cause_clear)
            cause_flag <= 1'b0;
    end

    assign reset_req = (state == PS_HOLD);

    AST_FLAG_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> cause_flag); // R6

    AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req && (held != LEN_W'(PULSE_LEN - 1)) |=> reset_req); // R5

    AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req && (held == LEN_W'(PULSE_LEN - 1)) |=> !reset_req); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cause_flag && !cause_clear |=> cause_flag); // R7

    AST_NO_FIRE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> !expire); // R9

endmodule

// File: rtl/wdt_reset_timer.sv
// Watchdog reset timer top. Arms on the first restart after power-on reset,
// times PRESCALE*MACHINE_CYCLES clocks, and requests a processor reset when
// the interval lapses with reset_enable set.
// Assumes: restart_pulse and reset_enable are already filtered by a
// write-protection unit; rst_n is synchronous to clk.
module wdt_reset_timer #(
    parameter int unsigned PRESCALE       = 12,
    parameter int unsigned MACHINE_CYCLES = 122800,
    parameter int unsigned PULSE_LEN      = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_pulse,
    input  logic reset_enable,
    input  logic cause_clear,
    output logic reset_req,
    output logic cause_flag
);

    logic armed;
    logic run;
    logic clr;
    logic tick;
    logic expire;

    // Arm on the first restart; power-on reset disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (restart_pulse)
            armed <= 1'b1;
    end

    assign run = armed && !reset_req;
    assign clr = !armed || expire || (restart_pulse && !reset_req);

    wdt_prescaler #(
        .PRESCALE (PRESCALE)
    ) u_prescaler (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .run   (run),
        .tick  (tick)
    );

    wdt_interval_counter #(
        .MACHINE_CYCLES (MACHINE_CYCLES)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .tick   (tick),
        .expire (expire)
    );

    wdt_reset_pulser #(
        .PULSE_LEN (PULSE_LEN)
    ) u_pulser (
        .clk          (clk),
        .rst_n        (rst_n),
        .expire       (expire),
        .reset_enable (reset_enable),
        .cause_clear  (cause_clear),
        .reset_req    (reset_req),
        .cause_flag   (cause_flag)
    );

    AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> $past(reset_enable)); // R4

    AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !expire && !reset_req); // R1

    AST_PULSE_AFTER_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> $past(expire)); // R2

endmodule

// File: tb/wdt_reset_timer_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks enqueue expected outputs per cycle,
// a falling-edge monitor pops and compares them.
module wdt_reset_timer_tb_top;

    localparam int P  = 3;
    localparam int M  = 10;
    localparam int L  = 4;
    localparam int PM = P * M;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic restart_pulse = 1'b0;
    logic reset_enable = 1'b0;
    logic cause_clear = 1'b0;
    logic reset_req;
    logic cause_flag;

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        logic  req;
        logic  flag;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    wdt_reset_timer #(
        .PRESCALE       (P),
        .MACHINE_CYCLES (M),
        .PULSE_LEN      (L)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .restart_pulse (restart_pulse),
        .reset_enable  (reset_enable),
        .cause_clear   (cause_clear),
        .reset_req     (reset_req),
        .cause_flag    (cause_flag)
    );

    // Insert an expected sample in cycle order.
    task automatic expect_at(input int at, input logic r, input logic f, input string tag);
        exp_t e;
        int   i;
        e.at = at; e.req = r; e.flag = f; e.tag = tag;
        i = 0;
        while (i < q.size() && q[i].at <= at) i++;
        q.insert(i, e);
    endtask

    // Wait for a falling edge with cyc >= c.
    task automatic tick_to(input int c);
        @(negedge clk);
        while (cyc < c) @(negedge clk);
    endtask

    // One-cycle restart; returns the edge number that samples it.
    task automatic pulse_restart(output int e0);
        @(negedge clk);
        restart_pulse = 1'b1;
        e0 = cyc + 1;
        @(negedge clk);
        restart_pulse = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: compare due expectations at the falling edge.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (e.at != cyc || reset_req !== e.req || cause_flag !== e.flag) begin
                errors++;
                $display("FAIL %s cyc=%0d (due %0d): req=%b flag=%b expected req=%b flag=%b",
                         e.tag, cyc, e.at, reset_req, cause_flag, e.req, e.flag);
            end
        end
    end

    // Watchdog against a hung run.
    always @(negedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run hung at cyc=%0d, expected completion", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int e0, e1, e2, e3, b, f, k;

        // R1: reset state and no request while never restarted
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_at(cyc + 1, 1'b0, 1'b0, "R1");
        reset_enable = 1'b1;
        expect_at(cyc + 2 * PM + 5, 1'b0, 1'b0, "R1");
        tick_to(cyc + 2 * PM + 7);

        // R2, R5, R6: timed request after a restart
        pulse_restart(e0);
        expect_at(e0 + PM - 1,     1'b0, 1'b0, "R2");
        expect_at(e0 + PM,         1'b1, 1'b1, "R2");
        expect_at(e0 + PM + L - 1, 1'b1, 1'b1, "R5");
        expect_at(e0 + PM + L,     1'b0, 1'b1, "R5");
        expect_at(e0 + PM + L + 5, 1'b0, 1'b1, "R6");
        // R9: restart during the pulse is ignored; timing resumes at pulse end
        b = e0 + 2 * PM + L;
        expect_at(b - 1, 1'b0, 1'b1, "R9");
        expect_at(b,     1'b1, 1'b1, "R9");
        tick_to(e0 + PM);
        restart_pulse = 1'b1;
        @(negedge clk);
        restart_pulse = 1'b0;

        // R7: software clear, then clear colliding with a watchdog reset
        tick_to(b + L + 2);
        k = cyc;
        expect_at(k + 1, 1'b0, 1'b0, "R7");
        cause_clear = 1'b1;
        @(negedge clk);
        cause_clear = 1'b0;
        f = b + L + PM;
        expect_at(f, 1'b1, 1'b1, "R7");
        tick_to(f - 1);
        cause_clear = 1'b1;
        @(negedge clk);
        cause_clear = 1'b0;

        // R8: power-on reset mid-pulse clears outputs and disarms
        tick_to(f + 1);
        expect_at(cyc + 1, 1'b0, 1'b0, "R8");
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        k = cyc;
        expect_at(k + PM + 20, 1'b0, 1'b0, "R8");
        tick_to(k + PM + 21);

        // R3: a second restart reloads the interval
        pulse_restart(e1);
        tick_to(e1 + 19);
        restart_pulse = 1'b1;
        e2 = cyc + 1;
        @(negedge clk);
        restart_pulse = 1'b0;
        expect_at(e1 + PM,     1'b0, 1'b0, "R3");
        expect_at(e2 + PM - 1, 1'b0, 1'b0, "R3");
        expect_at(e2 + PM,     1'b1, 1'b1, "R3");
        tick_to(e2 + PM + L + 1);
        do_reset();

        // R4: expiry with reset disabled does nothing and starts a fresh interval
        reset_enable = 1'b0;
        pulse_restart(e3);
        expect_at(e3 + PM,         1'b0, 1'b0, "R4");
        expect_at(e3 + PM + 3,     1'b0, 1'b0, "R4");
        expect_at(e3 + 2 * PM - 1, 1'b0, 1'b0, "R4");
        expect_at(e3 + 2 * PM,     1'b1, 1'b1, "R4");
        tick_to(e3 + PM + 10);
        reset_enable = 1'b1;
        tick_to(e3 + 2 * PM + L + 2);

        tick_to(cyc + 2);
        if (q.size() != 0) begin
            errors += q.size();
            checks += q.size();
            $display("FAIL scoreboard: %0d expectations never sampled, expected 0", q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule